// File: doc/BRIEF.md
# ADPCM Memory Data-Port Controller

This block sits between a processor's register interface and a byte-wide sample memory. It also sits between that interface and an ADPCM decoder. Through one data register the processor can do three things: read the sample memory one byte at a time, write it one byte at a time, or hand bytes straight to the decoder. The top three bits of the control register pick which of these the data register does.

For memory access, the block keeps a running address in nibble units. The address spans from a programmed start pointer up to a programmed end pointer. Two flags report progress. The ready flag drops for one cycle after each byte moved, and stays low while a fed byte waits for the decoder. The end flag is raised when an access finds the address already at the end pointer.

The controller is built around one state machine. Its states are:
- `P_IDLE`: no data-port mode.
- `P_PRIME`: two throw-away reads are pending after memory mode is chosen.
- `P_OPEN`: ready for a transfer.
- `P_HOLD`: the one-cycle busy slot after a transfer.
- `P_FEED`: a processor byte is waiting for the decoder.

Its transitions are:
- A control write goes to `P_PRIME` when memory mode is selected, to `P_OPEN` in feed mode, and to `P_IDLE` otherwise, including on a reset request.
- `P_PRIME` moves to `P_OPEN` on its second read. It moves to `P_HOLD`, or to `P_OPEN` at the end pointer, on the first write.
- `P_OPEN` moves to `P_HOLD` on a transfer and to `P_FEED` on a feed write.
- `P_HOLD` always returns to `P_OPEN`.
- `P_FEED` returns to `P_OPEN` when the decoder takes the byte.

Top module: `adp_data_port`

## Requirements
- R1: After reset, `brdy` is 1, `eos`, `pcm_busy`, `feed_full`, `rpt_en`, `rd_valid`, `mem_re` and `mem_we` are 0.
- R2: A control write (`reg_sel`=0) stores bits 7,6,5,4,0 of the value; bit 7 (start) sets `pcm_busy`, bit 4 drives `rpt_en`; bits [7:5] of the stored value select the mode: 001 memory read, 011 memory write, 100 decoder feed; any other value leaves the data register inert.
- R3: A control write with bit 5 set loads the address with the start pointer and arms two throw-away reads; the first two data reads (`dat_re`) each give `rd_valid` one cycle later with `rd_data`=0 and no memory strobe.
- R4: After the throw-away reads, each data read in read mode strobes `mem_re` at the current byte address in the same cycle, returns that byte on `rd_data` with `rd_valid` one cycle later, and advances the address by one byte (two nibbles).
- R5: Start byte address is start register << SHIFT; end byte address is (end register << SHIFT) with the SHIFT low bits set to 1; start and end registers are 16 bits, low byte at `reg_sel` 2/4, high byte at 3/5.
- R6: A data access made when the address equals the end pointer moves no data, returns 0, and sets `eos`.
- R7: Each transfer holds `brdy` low for exactly the following cycle; a data access made in that cycle is dropped (no strobe, no address change, read returns 0).
- R8: In write mode the first data write (`reg_sel`=1) cancels pending throw-away reads, reloads the address from start and writes `reg_wdata` there; later writes go to following bytes.
- R9: In feed mode a data write places the byte on `feed_byte`, sets `feed_full` and clears `brdy`; a `dec_take` pulse sets `brdy` and clears `feed_full` in the next cycle.
- R10: A control write with bit 0 set clears the mode, `pcm_busy` and `rpt_en` and sets `brdy`, regardless of the other bits.
- R11: `eos` stays set until the next control write, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 data, 2/3 start low/high, 4/5 end low/high |
| reg_wdata | input | 8 | Register write value |
| dat_re | input | 1 | Data register read strobe |
| rd_valid | output | 1 | Read result valid, one cycle after `dat_re` |
| rd_data | output | 8 | Read result |
| mem_addr | output | 16+SHIFT | Byte address to sample memory |
| mem_re | output | 1 | Memory read strobe (data due next cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| dec_take | input | 1 | Decoder has consumed the fed byte |
| feed_byte | output | 8 | Byte held for the decoder |
| feed_full | output | 1 | A fed byte is waiting |
| brdy | output | 1 | Ready flag |
| eos | output | 1 | End-of-span flag |
| pcm_busy | output | 1 | Started and not reset |
| rpt_en | output | 1 | Stored repeat bit for the decoder |

## Verification
The in-line properties check several rules on every cycle:
- the one-cycle ready drop after any strobe and its return;
- that no strobe is ever issued at the end pointer or during the throw-away reads;
- that the end flag stays set between control writes;
- the effect of the reset bit;
- that a feed write is latched;
- the one-cycle read response.

Only the bench scenarios can show other points. These are the byte order and address mapping against a memory model, and the exact count of throw-away reads. They also cover write-then-readback contents, the dropping of an access in the busy slot, and the handshake with the decoder.

// File: rtl/adp_port_pkg.sv
package adp_port_pkg;

    typedef enum logic [2:0] {
        P_IDLE,
        P_PRIME,
        P_OPEN,
        P_HOLD,
        P_FEED
    } port_st_t;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_DATA   = 3'd1;
    localparam logic [2:0] SEL_STA_LO = 3'd2;
    localparam logic [2:0] SEL_STA_HI = 3'd3;
    localparam logic [2:0] SEL_FIN_LO = 3'd4;
    localparam logic [2:0] SEL_FIN_HI = 3'd5;

    localparam logic [2:0] MODE_XRD  = 3'b001;
    localparam logic [2:0] MODE_XWR  = 3'b011;
    localparam logic [2:0] MODE_FEED = 3'b100;

    localparam int CB_START = 7;
    localparam int CB_MEM   = 5;
    localparam int CB_RPT   = 4;
    localparam int CB_RST   = 0;

    localparam logic [7:0] KEEP_MASK = 8'hF1;

endpackage

// File: rtl/adp_span_regs.sv
module adp_span_regs
    import adp_port_pkg::*;
#(
    parameter int SHIFT = 5,
    localparam int NW   = 16 + SHIFT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [7:0]    reg_wdata,
    output logic [NW-1:0] start_nib,
    output logic [NW-1:0] end_nib
);

    logic [15:0] sta_q;
    logic [15:0] fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q <= '0;
            fin_q <= '0;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_STA_LO: sta_q[7:0]  <= reg_wdata;
                SEL_STA_HI: sta_q[15:8] <= reg_wdata;
                SEL_FIN_LO: fin_q[7:0]  <= reg_wdata;
                SEL_FIN_HI: fin_q[15:8] <= reg_wdata;
                default: ;
            endcase
        end
    end

    generate
        if (SHIFT == 0) begin : g_flat
            assign start_nib = {sta_q, 1'b0};
            assign end_nib   = {fin_q, 1'b0};
        end else begin : g_scaled
            assign start_nib = {sta_q, {SHIFT{1'b0}}, 1'b0};
            assign end_nib   = {fin_q, {SHIFT{1'b1}}, 1'b0};
        end
    endgenerate

endmodule

// File: rtl/adp_read_ret.sv
module adp_read_ret (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dat_rd,
    input  logic       fetch,
    input  logic [7:0] mem_rdata,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    logic fetch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            fetch_q  <= 1'b0;
        end else begin
            rd_valid <= dat_rd;
            fetch_q  <= fetch;
        end
    end

    assign rd_data = fetch_q ? mem_rdata : 8'h00;

    // R3
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd |=> rd_valid);

    // R4
    fetch_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> dat_rd);

endmodule

// File: rtl/adp_port_fsm.sv
module adp_port_fsm
    import adp_port_pkg::*;
#(
    parameter int NW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_val,
    input  logic          dat_wr,
    input  logic [7:0]    dat_val,
    input  logic          dat_rd,
    input  logic          dec_take,
    input  logic [NW-1:0] start_nib,
    input  logic [NW-1:0] end_nib,
    output logic [NW-2:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [7:0]    feed_byte,
    output logic          feed_full,
    output logic          brdy,
    output logic          eos,
    output logic          pcm_busy,
    output logic          rpt_en
);

    localparam logic [NW-1:0] NIB_STEP = NW'(2);

    port_st_t      st_q, st_nx;
    logic [7:0]    ps_q, ps_nx;
    logic [NW-1:0] nib_q, nib_nx;
    logic [1:0]    dum_q, dum_nx;
    logic          eos_q, eos_nx;
    logic          busy_q, busy_nx;
    logic [7:0]    feed_q, feed_nx;

    logic [2:0] mode;
    logic       at_end;
    logic       sta_at_end;
    logic       rd_mode;
    logic       wr_mode;

    assign mode       = ps_q[7:5];
    assign at_end     = (nib_q == end_nib);
    assign sta_at_end = (start_nib == end_nib);
    assign rd_mode    = (mode == MODE_XRD);
    assign wr_mode    = (mode == MODE_XWR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= P_IDLE;
            ps_q   <= '0;
            nib_q  <= '0;
            dum_q  <= '0;
            eos_q  <= 1'b0;
            busy_q <= 1'b0;
            feed_q <= '0;
        end else begin
            st_q   <= st_nx;
            ps_q   <= ps_nx;
            nib_q  <= nib_nx;
            dum_q  <= dum_nx;
            eos_q  <= eos_nx;
            busy_q <= busy_nx;
            feed_q <= feed_nx;
        end
    end

    // next state
    always_comb begin
        st_nx   = st_q;
        ps_nx   = ps_q;
        nib_nx  = nib_q;
        dum_nx  = dum_q;
        eos_nx  = eos_q;
        busy_nx = busy_q;
        feed_nx = feed_q;
        if (ctl_wr) begin
            eos_nx = 1'b0;
            if (ctl_val[CB_RST]) begin
                ps_nx   = '0;
                busy_nx = 1'b0;
                dum_nx  = '0;
                st_nx   = P_IDLE;
            end else begin
                ps_nx = ctl_val & KEEP_MASK;
                if (ctl_val[CB_START]) begin
                    busy_nx = 1'b1;
                end
                if (ctl_val[CB_MEM]) begin
                    nib_nx = start_nib;
                    dum_nx = 2'd2;
                    st_nx  = P_PRIME;
                end else begin
                    nib_nx = '0;
                    dum_nx = '0;
                    st_nx  = (ctl_val[7:5] == MODE_FEED) ? P_OPEN : P_IDLE;
                end
            end
        end else begin
            unique case (st_q)
                P_IDLE: ;
                P_PRIME: begin
                    if (dat_rd && rd_mode) begin
                        nib_nx = start_nib;
                        dum_nx = dum_q - 2'd1;
                        if (dum_q == 2'd1) begin
                            st_nx = P_OPEN;
                        end
                    end else if (dat_wr && wr_mode) begin
                        dum_nx = '0;
                        if (sta_at_end) begin
                            eos_nx = 1'b1;
                            nib_nx = start_nib;
                            st_nx  = P_OPEN;
                        end else begin
                            nib_nx = start_nib + NIB_STEP;
                            st_nx  = P_HOLD;
                        end
                    end
                end
                P_OPEN: begin
                    if ((dat_rd && rd_mode) || (dat_wr && wr_mode)) begin
                        if (at_end) begin
                            eos_nx = 1'b1;
                        end else begin
                            nib_nx = nib_q + NIB_STEP;
                            st_nx  = P_HOLD;
                        end
                    end else if (dat_wr && mode == MODE_FEED) begin
                        feed_nx = dat_val;
                        st_nx   = P_FEED;
                    end
                end
                P_HOLD: st_nx = P_OPEN;
                P_FEED: begin
                    if (dat_wr) begin
                        feed_nx = dat_val;
                    end else if (dec_take) begin
                        st_nx = P_OPEN;
                    end
                end
                default: st_nx = P_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_re    = !ctl_wr && dat_rd && rd_mode && (st_q == P_OPEN) && !at_end;
        mem_we    = !ctl_wr && dat_wr && wr_mode &&
                    (((st_q == P_OPEN) && !at_end) || ((st_q == P_PRIME) && !sta_at_end));
        mem_addr  = (st_q == P_PRIME) ? start_nib[NW-1:1] : nib_q[NW-1:1];
        brdy      = !((st_q == P_HOLD) || (st_q == P_FEED));
        feed_full = (st_q == P_FEED);
        feed_byte = feed_q;
        eos       = eos_q;
        pcm_busy  = busy_q;
        rpt_en    = ps_q[CB_RPT];
    end

    // R7
    xfer_brdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |=> !brdy);

    // R7
    brdy_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == P_HOLD) |=> brdy);

    // R6
    end_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> ({mem_addr, 1'b0} != end_nib));

    // R3
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == P_PRIME) |-> !mem_re);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R11
    eos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !ctl_wr) |=> eos);

    // R10
    reset_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_val[CB_RST]) |=> (!pcm_busy && brdy && ps_q == 8'h00));

    // R9
    feed_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && dat_wr && st_q == P_OPEN && mode == MODE_FEED)
        |=> (!brdy && feed_full && feed_byte == $past(dat_val)));

endmodule

// File: rtl/adp_data_port.sv
module adp_data_port
    import adp_port_pkg::*;
#(
    parameter int SHIFT = 5,
    localparam int AW   = 16 + SHIFT,
    localparam int NW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [7:0]    reg_wdata,
    input  logic          dat_re,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          dec_take,
    output logic [7:0]    feed_byte,
    output logic          feed_full,
    output logic          brdy,
    output logic          eos,
    output logic          pcm_busy,
    output logic          rpt_en
);

    logic          ctl_wr;
    logic          dat_wr;
    logic [NW-1:0] start_nib;
    logic [NW-1:0] end_nib;

    assign ctl_wr    = reg_we && (reg_sel == SEL_CTRL);
    assign dat_wr    = reg_we && (reg_sel == SEL_DATA);
    assign mem_wdata = reg_wdata;

    adp_span_regs #(.SHIFT(SHIFT)) u_span (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .start_nib (start_nib),
        .end_nib   (end_nib)
    );

    adp_port_fsm #(.NW(NW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_val   (reg_wdata),
        .dat_wr    (dat_wr),
        .dat_val   (reg_wdata),
        .dat_rd    (dat_re),
        .dec_take  (dec_take),
        .start_nib (start_nib),
        .end_nib   (end_nib),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .feed_byte (feed_byte),
        .feed_full (feed_full),
        .brdy      (brdy),
        .eos       (eos),
        .pcm_busy  (pcm_busy),
        .rpt_en    (rpt_en)
    );

    adp_read_ret u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_rd    (dat_re),
        .fetch     (mem_re),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sim_adp_data_port.sv
module sim_adp_data_port;

    localparam int CLK_PERIOD = 10;
    localparam int SHIFT      = 2;
    localparam int AW         = 16 + SHIFT;

    localparam logic [1:0] K_W = 2'd0;
    localparam logic [1:0] K_R = 2'd1;
    localparam logic [1:0] K_D = 2'd2;

    // fields: kind[22:21] sel[20:18] wdata[17:10] expect[9:2] eos[1] xfer[0]
    localparam int NVEC = 26;
    localparam logic [22:0] VEC [0:NVEC-1] = '{
        {K_W, 3'd2, 8'h01, 8'h00, 1'b0, 1'b0},
        {K_W, 3'd4, 8'h02, 8'h00, 1'b0, 1'b0},
        {K_W, 3'd0, 8'h20, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'h0D, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h10, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h13, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h16, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h19, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h1C, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h1F, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0},
        {K_W, 3'd4, 8'h01, 8'h00, 1'b1, 1'b0},
        {K_W, 3'd0, 8'h60, 8'h00, 1'b0, 1'b0},
        {K_D, 3'd1, 8'hA5, 8'h00, 1'b0, 1'b1},
        {K_D, 3'd1, 8'h3C, 8'h00, 1'b0, 1'b1},
        {K_D, 3'd1, 8'h96, 8'h00, 1'b0, 1'b1},
        {K_D, 3'd1, 8'h77, 8'h00, 1'b1, 1'b0},
        {K_W, 3'd0, 8'h20, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {K_R, 3'd0, 8'h00, 8'hA5, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h3C, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h96, 1'b0, 1'b1},
        {K_R, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic          dat_re = 1'b0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          dec_take = 1'b0;
    logic [7:0]    feed_byte;
    logic          feed_full;
    logic          brdy;
    logic          eos;
    logic          pcm_busy;
    logic          rpt_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
    end

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    adp_data_port #(.SHIFT(SHIFT)) u0 (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .dat_re (dat_re), .rd_valid (rd_valid),
        .rd_data (rd_data), .mem_addr (mem_addr), .mem_re (mem_re),
        .mem_we (mem_we), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .dec_take (dec_take), .feed_byte (feed_byte), .feed_full (feed_full),
        .brdy (brdy), .eos (eos), .pcm_busy (pcm_busy), .rpt_en (rpt_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic data_rd();
        @(negedge clk);
        dat_re = 1'b1;
        @(negedge clk);
        dat_re = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 40000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(brdy && !eos && !pcm_busy && !feed_full && !rpt_en && !rd_valid && !mem_re && !mem_we,
            "R1 reset outputs", {brdy, eos, pcm_busy, feed_full, rpt_en, rd_valid}, 6'b100000);

        // table: R3 R4 R5 R6 R7 R8 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] kind;
            logic [7:0] exp_d;
            kind  = VEC[v][22:21];
            exp_d = VEC[v][9:2];
            @(negedge clk);
            if (kind == K_R) begin
                dat_re = 1'b1;
            end else begin
                reg_we = 1'b1; reg_sel = VEC[v][20:18]; reg_wdata = VEC[v][17:10];
            end
            @(negedge clk);
            dat_re = 1'b0; reg_we = 1'b0;
            if (kind == K_R) begin
                chk(rd_valid && rd_data == exp_d, "R4 read data", rd_data, exp_d);
            end
            if (kind != K_W) begin
                chk(brdy == !VEC[v][0], "R7 brdy after access", brdy, !VEC[v][0]);
            end
            @(negedge clk);
            chk(brdy && eos == VEC[v][1], "R6 R11 eos and brdy", {brdy, eos}, {1'b1, VEC[v][1]});
        end

        // R5 address mapping with high bytes
        reg_wr(3'd2, 8'h01); reg_wr(3'd3, 8'h01);
        reg_wr(3'd4, 8'h01); reg_wr(3'd5, 8'h01);
        reg_wr(3'd0, 8'h20);
        data_rd(); data_rd();
        @(negedge clk);
        dat_re = 1'b1;
        #1;
        chk(mem_re && mem_addr == 18'h00404, "R5 byte address", mem_addr, 18'h00404);
        @(negedge clk);
        dat_re = 1'b0;
        chk(rd_data == 8'hA5, "R5 read at mapped start", rd_data, 8'hA5);
        @(negedge clk);
        reg_wr(3'd3, 8'h00); reg_wr(3'd5, 8'h00);

        // R7 access in busy slot is dropped
        reg_wr(3'd2, 8'h00); reg_wr(3'd4, 8'h00);
        reg_wr(3'd0, 8'h20);
        data_rd(); data_rd();
        @(negedge clk);
        dat_re = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h01, "R4 first byte", rd_data, 8'h01);
        @(negedge clk);
        dat_re = 1'b0;
        chk(rd_valid && rd_data == 8'h00, "R7 dropped read", rd_data, 8'h00);
        @(negedge clk);
        data_rd();
        @(negedge clk);
        dat_re = 1'b1;
        @(negedge clk);
        dat_re = 1'b0;
        chk(rd_data == 8'h07, "R7 address not advanced by dropped read", rd_data, 8'h07);
        @(negedge clk);

        // R9 decoder feed
        reg_wr(3'd0, 8'h80);
        chk(pcm_busy && brdy && !feed_full, "R2 start sets busy", {pcm_busy, brdy, feed_full}, 3'b110);
        reg_wr(3'd1, 8'h4E);
        chk(feed_full && !brdy && feed_byte == 8'h4E, "R9 feed latched", feed_byte, 8'h4E);
        repeat (3) @(negedge clk);
        chk(feed_full && !brdy, "R9 feed held", {feed_full, brdy}, 2'b10);
        dec_take = 1'b1;
        @(negedge clk);
        dec_take = 1'b0;
        chk(brdy && !feed_full, "R9 taken", {brdy, feed_full}, 2'b10);

        // R2 repeat bit, R10 reset bit
        reg_wr(3'd0, 8'hB0);
        chk(rpt_en && pcm_busy, "R2 repeat stored", {rpt_en, pcm_busy}, 2'b11);
        reg_wr(3'd0, 8'hB1);
        chk(!rpt_en && !pcm_busy && brdy, "R10 reset bit", {rpt_en, pcm_busy, brdy}, 3'b001);
        @(negedge clk);
        dat_re = 1'b1;
        #1;
        chk(!mem_re, "R10 no mode after reset bit", mem_re, 0);
        @(negedge clk);
        dat_re = 1'b0;
        chk(rd_data == 8'h00, "R2 inert read", rd_data, 8'h00);

        // R2 spoff-only value leaves port inert
        reg_wr(3'd0, 8'h08);
        reg_wr(3'd1, 8'h55);
        chk(!rpt_en && brdy && !feed_full && mem[0] == 8'h01, "R2 inert write",
            {rpt_en, brdy, feed_full}, 3'b010);

        finish_run();
    end

endmodule